// File: doc/BRIEF.md
# Virtual Function Memory Aperture Decoder

This block takes a memory request address and works out which virtual function owns it. One base register describes a single aperture shared by every active virtual function. The aperture is split into equal slices, one per function, and each slice is a power of two in size. The slice size is the lowest set bit of the size mask that the base register returns after all ones are written to it. The aperture holds as many slices as there are active functions.

For each request the block reports whether the address falls inside a live slice. On a hit it also gives the 1-based index of the owning function and the offset of the address inside that slice. Decoding is gated by a global function enable, by a memory space enable that covers all functions together, and by the active function count. The outputs are registered and arrive one cycle after the request strobe. One instance serves one 32-bit base register, so a design that uses several base registers places one instance per register. The physical function's own address space is handled elsewhere and never reaches this decoder.

Top module: `vf_aperture_decoder`

## Requirements
- R1: While reset is held and right after it is released, `hitValid` and `hit` are 0 and `vfIndex` and `sliceOffset` are 0.
- R2: `hitValid` is 1 in exactly the cycle after a cycle in which `reqValid` was 1, and `hit` is never 1 while `hitValid` is 0.
- R3: The slice size is the lowest set bit of `sizeMask`. When `sizeMask` is all zeros, no request hits.
- R4: On a hit, `vfIndex` equals ((address minus the aligned base) divided by the slice size) plus 1, and `sliceOffset` equals that difference modulo the slice size. The aligned base is `barBase` with the bits below the slice size cleared.
- R5: An address below the aligned base gives no hit. This includes addresses near zero when the aperture sits at the top of the address space.
- R6: An address at or above the aligned base plus slice size times `numVfs` gives no hit, and no address hits while `numVfs` is 0. An aperture that extends past the top of the 32-bit space still decodes every address up to all ones.
- R7: While `vfEnable` is 0, no request hits, whatever the value of `vfMemEnable`.
- R8: While `vfMemEnable` is 0, no request hits, even with `vfEnable` at 1.
- R9: A request that misses reports `vfIndex` and `sliceOffset` as 0. In cycles with no request, `vfIndex` and `sliceOffset` keep the values of the last request.
- R10: The gating inputs, the base, the mask and the count are all sampled on the same clock edge as the request they apply to. A change takes effect for a request in the same cycle and has no effect on results that are already registered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe |
| reqAddr | input | 32 | Request memory address |
| barBase | input | 32 | Programmed base of the shared aperture |
| sizeMask | input | 32 | Read-back size mask of the base register |
| numVfs | input | 16 | Active virtual function count |
| vfEnable | input | 1 | Global virtual function enable |
| vfMemEnable | input | 1 | Collective memory space enable for all functions |
| hitValid | output | 1 | Result strobe, one cycle after the request |
| hit | output | 1 | Address falls in a live slice |
| vfIndex | output | 16 | 1-based owning function, 0 on a miss |
| sliceOffset | output | 32 | Offset inside the slice, 0 on a miss |

## Verification
Two things can land in the same cycle: a request, and a change to the gating or geometry inputs (enables, count, base or mask). The bench provokes this by changing an input in exactly the cycle of a request, then sending the next request back to back under the new setting. The reference model samples the inputs at the same edge as the request, so each result is judged against the setting in force in that request's own cycle. Boundary addresses are also checked: the first and last byte of the aperture, the byte just past it, and apertures that run past the top of the address space.

// File: rtl/vfdec_pkg.sv
package vfdec_pkg;
  // strobes handed from control to datapath each cycle
  typedef struct packed {
    logic capture;   // a request is present this cycle
    logic gateOpen;  // enables, count and mask allow decoding
  } dec_strobe_t;
endpackage

// File: rtl/vfdec_sizer.sv
module vfdec_sizer #(
  parameter int ADDR_W = 32,
  localparam int SH_W = $clog2(ADDR_W)
) (
  input  logic [ADDR_W-1:0] sizeMask,
  output logic [ADDR_W-1:0] sliceMask,
  output logic [SH_W-1:0]   shiftAmt,
  output logic              maskValid
);
  logic [ADDR_W-1:0] lowBit;
  logic [SH_W-1:0][ADDR_W-1:0] pick;

  // isolate lowest set bit: that bit is the slice size
  assign lowBit    = sizeMask & (~sizeMask + 1'b1);
  assign sliceMask = lowBit - 1'b1;
  assign maskValid = |sizeMask;

  // one-hot to binary encoder built from constant select patterns
  for (genvar b = 0; b < SH_W; b++) begin : g_encBit
    for (genvar i = 0; i < ADDR_W; i++) begin : g_src
      if (((i >> b) & 1) == 1) begin : g_on
        assign pick[b][i] = lowBit[i];
      end else begin : g_off
        assign pick[b][i] = 1'b0;
      end
    end
    assign shiftAmt[b] = |pick[b];
  end
endmodule

// File: rtl/vfdec_ctrl.sv
module vfdec_ctrl
  import vfdec_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             vfEnable,
  input  logic             vfMemEnable,
  input  logic [CNT_W-1:0] numVfs,
  input  logic             maskValid,
  output dec_strobe_t      strobes,
  output logic             hitValid
);
  always_comb begin
    strobes.capture  = reqValid;
    strobes.gateOpen = vfEnable & vfMemEnable & (|numVfs) & maskValid;
  end

  always_ff @(posedge clk) begin
    if (!rstN) hitValid <= 1'b0;
    else       hitValid <= reqValid;
  end
endmodule

// File: rtl/vfdec_datapath.sv
module vfdec_datapath
  import vfdec_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  localparam int SH_W  = $clog2(ADDR_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dec_strobe_t       strobes,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [ADDR_W-1:0] barBase,
  input  logic [CNT_W-1:0]  numVfs,
  input  logic [ADDR_W-1:0] sliceMask,
  input  logic [SH_W-1:0]   shiftAmt,
  output logic              hit,
  output logic [CNT_W-1:0]  vfIndex,
  output logic [ADDR_W-1:0] sliceOffset
);
  logic [ADDR_W-1:0] alignedBase;
  logic [ADDR_W:0]   relWide;
  logic [ADDR_W-1:0] slotNum;
  logic              inRange;
  logic              takeHit;

  assign alignedBase = barBase & ~sliceMask;
  assign relWide     = {1'b0, reqAddr} - {1'b0, alignedBase};
  assign slotNum     = relWide[ADDR_W-1:0] >> shiftAmt;
  // borrow out means the address lies below the base
  assign inRange     = !relWide[ADDR_W] && (slotNum < ADDR_W'(numVfs));
  assign takeHit     = strobes.capture & strobes.gateOpen & inRange;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hit         <= 1'b0;
      vfIndex     <= '0;
      sliceOffset <= '0;
    end else begin
      hit <= takeHit;
      if (strobes.capture) begin
        if (takeHit) begin
          vfIndex     <= slotNum[CNT_W-1:0] + 1'b1;
          sliceOffset <= relWide[ADDR_W-1:0] & sliceMask;
        end else begin
          vfIndex     <= '0;
          sliceOffset <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/vf_aperture_decoder.sv
module vf_aperture_decoder
  import vfdec_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [ADDR_W-1:0] barBase,
  input  logic [ADDR_W-1:0] sizeMask,
  input  logic [CNT_W-1:0]  numVfs,
  input  logic              vfEnable,
  input  logic              vfMemEnable,
  output logic              hitValid,
  output logic              hit,
  output logic [CNT_W-1:0]  vfIndex,
  output logic [ADDR_W-1:0] sliceOffset
);
  localparam int SH_W = $clog2(ADDR_W);

  dec_strobe_t       strobes;
  logic [ADDR_W-1:0] sliceMask;
  logic [SH_W-1:0]   shiftAmt;
  logic              maskValid;

  vfdec_sizer #(.ADDR_W(ADDR_W)) sizer_i (
    .sizeMask (sizeMask),
    .sliceMask(sliceMask),
    .shiftAmt (shiftAmt),
    .maskValid(maskValid)
  );

  vfdec_ctrl #(.CNT_W(CNT_W)) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .vfEnable   (vfEnable),
    .vfMemEnable(vfMemEnable),
    .numVfs     (numVfs),
    .maskValid  (maskValid),
    .strobes    (strobes),
    .hitValid   (hitValid)
  );

  vfdec_datapath #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .reqAddr    (reqAddr),
    .barBase    (barBase),
    .numVfs     (numVfs),
    .sliceMask  (sliceMask),
    .shiftAmt   (shiftAmt),
    .hit        (hit),
    .vfIndex    (vfIndex),
    .sliceOffset(sliceOffset)
  );
endmodule

// File: rtl/vfdec_checker.sv
module vfdec_checker #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic [ADDR_W-1:0] reqAddr,
  input logic [ADDR_W-1:0] barBase,
  input logic [ADDR_W-1:0] sizeMask,
  input logic [CNT_W-1:0]  numVfs,
  input logic              vfEnable,
  input logic              vfMemEnable,
  input logic              hitValid,
  input logic              hit,
  input logic [CNT_W-1:0]  vfIndex,
  input logic [ADDR_W-1:0] sliceOffset
);
  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> hitValid);
  // R2
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !hitValid);
  // R2
  hit_needs_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    hit |-> hitValid);
  // R7
  enable_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !vfEnable) |=> !hit);
  // R8
  mse_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !vfMemEnable) |=> !hit);
  // R6
  zero_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && numVfs == '0) |=> !hit);
  // R3
  zero_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && sizeMask == '0) |=> !hit);
  // R4
  index_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && numVfs != '0) |=> (!hit || (vfIndex != '0 && vfIndex <= $past(numVfs))));
  // R9
  miss_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hitValid && !hit) |-> (vfIndex == '0 && sliceOffset == '0));
  // R9
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!reqValid && hitValid) |=> ($stable(vfIndex) && $stable(sliceOffset)));
endmodule

bind vf_aperture_decoder vfdec_checker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) chk_i (.*);

// File: tb/vf_aperture_decoder_tb_top.sv
`timescale 1ns/1ps
module vf_aperture_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [31:0] reqAddr = '0;
  logic [31:0] barBase = '0;
  logic [31:0] sizeMask = '0;
  logic [15:0] numVfs = '0;
  logic        vfEnable = 1'b0;
  logic        vfMemEnable = 1'b0;
  logic        hitValid, hit;
  logic [15:0] vfIndex;
  logic [31:0] sliceOffset;

  // setting applied together with the next request
  logic [31:0] cfgBase = '0;
  logic [31:0] cfgMask = '0;
  logic [15:0] cfgNum = '0;
  logic        cfgEn = 1'b0;
  logic        cfgMse = 1'b0;

  // expected outputs for the coming edge
  logic        expValid = 1'b0;
  logic        expHit = 1'b0;
  logic [15:0] expIdx = '0;
  logic [31:0] expOff = '0;
  string       expTag = "R1";

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  vf_aperture_decoder dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .barBase(barBase), .sizeMask(sizeMask), .numVfs(numVfs),
    .vfEnable(vfEnable), .vfMemEnable(vfMemEnable),
    .hitValid(hitValid), .hit(hit), .vfIndex(vfIndex), .sliceOffset(sliceOffset)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run hung after %0d cycles (expected end)", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic compareAll(input string tag);
    checks++;
    if (hitValid !== expValid || hit !== expHit || vfIndex !== expIdx || sliceOffset !== expOff) begin
      errors++;
      $display("FAIL %s: got valid=%0b hit=%0b idx=%0d off=%h expected valid=%0b hit=%0b idx=%0d off=%h",
               tag, hitValid, hit, vfIndex, sliceOffset, expValid, expHit, expIdx, expOff);
    end
  endtask

  // behavioural model of one request
  task automatic predict(input logic rv, input logic [31:0] addr);
    longint sz, base, a, limit;
    sz = 0;
    for (int k = 0; k < 32; k++) begin
      if (cfgMask[k]) begin
        sz = longint'(1) << k;
        break;
      end
    end
    expValid = rv;
    if (!rv) begin
      expHit = 1'b0;
      return;
    end
    a = longint'(addr);
    base = (sz == 0) ? 0 : (longint'(cfgBase) & ~(sz - 1));
    limit = base + sz * longint'(cfgNum);
    if (cfgEn && cfgMse && cfgNum != 0 && sz != 0 && a >= base && a < limit) begin
      expHit = 1'b1;
      expIdx = 16'((a - base) / sz + 1);
      expOff = 32'((a - base) % sz);
    end else begin
      expHit = 1'b0;
      expIdx = '0;
      expOff = '0;
    end
  endtask

  // one cycle: judge the previous result, then drive the next request
  task automatic step(input logic rv, input logic [31:0] addr, input string tag);
    @(negedge clk);
    compareAll(expTag);
    barBase = cfgBase;
    sizeMask = cfgMask;
    numVfs = cfgNum;
    vfEnable = cfgEn;
    vfMemEnable = cfgMse;
    reqValid = rv;
    reqAddr = addr;
    predict(rv, addr);
    expTag = tag;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs quiet during reset
    checks++;
    if (hitValid !== 1'b0 || hit !== 1'b0 || vfIndex !== '0 || sliceOffset !== '0) begin
      errors++;
      $display("FAIL R1: got valid=%0b hit=%0b idx=%0d off=%h expected all zero",
               hitValid, hit, vfIndex, sliceOffset);
    end
    rstN = 1'b1;
    step(1'b0, '0, "R1");
    step(1'b0, '0, "R1");

    // 4 KiB slices, four functions at 0x8000_0000
    cfgBase = 32'h8000_0000; cfgMask = 32'hFFFF_F000; cfgNum = 16'd4;
    cfgEn = 1'b1; cfgMse = 1'b1;
    step(1'b1, 32'h8000_0000, "R4");
    step(1'b1, 32'h8000_0FFF, "R4");
    step(1'b1, 32'h8000_1000, "R4");
    step(1'b1, 32'h8000_3FFF, "R6");
    step(1'b1, 32'h8000_4000, "R6");
    step(1'b1, 32'h7FFF_FFFF, "R5");
    step(1'b1, 32'h8000_2ABC, "R2");
    step(1'b0, 32'h8000_0000, "R9");
    step(1'b0, 32'h0000_0000, "R9");
    step(1'b1, 32'h9000_0000, "R9");

    // 64 KiB slices, unaligned base low bits dropped
    cfgBase = 32'h1234_5678; cfgMask = 32'hFFFF_0000; cfgNum = 16'd3;
    step(1'b1, 32'h1234_0000, "R4");
    step(1'b1, 32'h1235_0010, "R4");
    step(1'b1, 32'h1236_FFFF, "R4");
    step(1'b1, 32'h1237_0000, "R6");
    step(1'b1, 32'h1233_FFFF, "R5");

    // enable gating
    cfgEn = 1'b0; cfgMse = 1'b1;
    step(1'b1, 32'h1234_0004, "R7");
    cfgEn = 1'b0; cfgMse = 1'b0;
    step(1'b1, 32'h1234_0004, "R7");
    cfgEn = 1'b1; cfgMse = 1'b0;
    step(1'b1, 32'h1235_0004, "R8");
    cfgMse = 1'b1; cfgNum = 16'd0;
    step(1'b1, 32'h1234_0004, "R6");
    cfgNum = 16'd3; cfgMask = 32'h0000_0000;
    step(1'b1, 32'h1234_0004, "R3");
    // smallest slice: lowest bit 0 gives one-byte slices
    cfgMask = 32'hFFFF_FFFF; cfgBase = 32'h0000_0100;
    step(1'b1, 32'h0000_0102, "R3");
    step(1'b1, 32'h0000_0103, "R3");
    // mask with a hole above the lowest bit still uses the lowest bit
    cfgMask = 32'hF0F0_0200;
    step(1'b1, 32'h0000_0500, "R3");

    // aperture running past the top of the address space
    cfgBase = 32'hFFFF_0000; cfgMask = 32'hFFFF_C000; cfgNum = 16'd8;
    step(1'b1, 32'hFFFF_FFFF, "R6");
    step(1'b1, 32'h0000_0010, "R5");
    step(1'b1, 32'hFFFF_4001, "R4");

    // same-cycle setting changes with back-to-back requests
    cfgBase = 32'h4000_0000; cfgMask = 32'hFFFF_F000; cfgNum = 16'd2; cfgEn = 1'b1; cfgMse = 1'b1;
    step(1'b1, 32'h4000_1008, "R10");
    cfgEn = 1'b0;
    step(1'b1, 32'h4000_1008, "R10");
    cfgEn = 1'b1;
    step(1'b1, 32'h4000_0008, "R10");
    cfgNum = 16'd1;
    step(1'b1, 32'h4000_1008, "R10");
    cfgNum = 16'd2; cfgBase = 32'h4000_1000;
    step(1'b1, 32'h4000_1008, "R10");
    cfgMse = 1'b0;
    step(1'b0, 32'h4000_1008, "R10");
    step(1'b0, 32'h0, "R2");
    step(1'b0, 32'h0, "R2");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule